// File: doc/BRIEF.md
# Memory-Mapped Parallel Port

This block places a byte-wide input device and a byte-wide output device in the address space of a processor. The processor bus is asynchronous and uses a two-wire handshake. The processor raises master-ready with an address, a direction and write data. The port answers with slave-ready and holds it until master-ready falls. Three registers are reachable: a captured input code, a held output character, and a status word. The status word carries one readiness flag for each direction.

On the device side, a rising edge on the input strobe captures the input code and raises the input flag. A processor read of the input register lowers that flag. The output device raises its idle line when it can take a character, and this raises the output flag. A processor write of a character lowers the output flag, drives the character out and raises the output strobe. The strobe stays up until the device drops idle to show it has taken the character. Every asynchronous input (master-ready, the input strobe and idle) passes through a synchronizer of `SYNC_STAGES` flops before it is used. Address, direction and both data buses are assumed stable while their qualifying strobe is high.

Top module: `pario_port`

## Requirements
- R1: The port responds only when `bus_addr[31:2]` equals `BASE_ADDR[31:2]`. For any other address, `bus_srdy` stays low for as long as `bus_mrdy` is held.
- R2: For a matching address, `bus_srdy` rises SYNC_STAGES+1 clock edges after `bus_mrdy` rises. It stays high until `bus_mrdy` falls, and then drops SYNC_STAGES+1 edges after that fall. Each handshake performs exactly one register access.
- R3: `bus_addr[1:0]` selects the register: 0 is the input code, 1 is the output character and 2 is the status word. A read of offset 3 returns zero. Read data is zero-extended to 32 bits and is registered when slave-ready rises. A write returns zero on `bus_rdata`.
- R4: Status bit 0 is the input flag and bit 1 is the output flag. Bits 31:2 read as zero.
- R5: A rising edge on `dev_in_valid` loads `dev_in_code` into the input register and sets the input flag.
- R6: A read of offset 0 clears the input flag. If a new input edge arrives in the same cycle, the new edge wins.
- R7: A rising edge on `dev_out_idle` sets the output flag.
- R8: A write to offset 1 places `bus_wdata[7:0]` on `dev_out_code`, raises `dev_out_valid` and clears the output flag.
- R9: `dev_out_valid` falls SYNC_STAGES+1 clock edges after `dev_out_idle` falls.
- R10: Writes to offsets 0, 2 and 3 change no register, no flag and no device output.
- R11: After reset, `bus_srdy`, `bus_rdata`, `dev_out_code`, `dev_out_valid` and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 32 | Byte address from the processor |
| bus_wdata | input | 32 | Write data; only bits 7:0 are stored |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_mrdy | input | 1 | Master-ready, asynchronous |
| bus_srdy | output | 1 | Slave-ready answer |
| bus_rdata | output | 32 | Registered read data |
| dev_in_code | input | 8 | Code from the input device |
| dev_in_valid | input | 1 | Input strobe, asynchronous |
| dev_out_code | output | 8 | Character to the output device |
| dev_out_valid | output | 1 | Output strobe |
| dev_out_idle | input | 1 | Output device ready, asynchronous |

## Verification
Every response lags its cause by SYNC_STAGES+1 edges. The synchronizer adds SYNC_STAGES edges and the register that acts on the synchronized level adds one more. This holds for slave-ready rising and falling, for the flags, and for the fall of the output strobe. A write's effect on the output character and strobe shows at the first edge of the acknowledging cycle. The bench keeps its own history of the values it drove. At each edge, its reference model uses the values from SYNC_STAGES and SYNC_STAGES+1 edges earlier. Outputs are compared at every falling edge. The directed checks count falling edges from the moment a stimulus is driven, so the exact lag is checked rather than only the eventual value.

// File: rtl/pario_pkg.sv
// Package: pario_pkg
// Shared encodings for the parallel port. The register offsets are decoded
// from the two low address bits. The two status bit positions are seen by
// software and must not move.
package pario_pkg;

    typedef enum logic [1:0] {
        SEL_IN   = 2'd0,
        SEL_OUT  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        HS_IDLE = 1'b0,
        HS_ACK  = 1'b1
    } hs_state_e;

    // One decoded register access, valid for a single cycle
    typedef struct packed {
        logic     en;
        logic     write;
        reg_sel_e sel;
    } acc_t;

    localparam int STAT_IN_BIT  = 0;
    localparam int STAT_OUT_BIT = 1;

endpackage

// File: rtl/pario_sync.sv
// Module: pario_sync
// Brings one asynchronous level into the clock domain through a chain of
// STAGES flops. Assumes the input is a level that is held for longer than
// STAGES clock periods. Edge detection is left to the user of the level.
module pario_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single capture flop
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= async_in;
            end
        end else begin : g_chain
            // Shift the sample along the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign level = chain[STAGES-1];

endmodule

// File: rtl/pario_bus_fsm.sv
// Module: pario_bus_fsm
// Decodes the bus address and runs the slave-ready handshake. It issues a
// single access pulse when synchronized master-ready is seen on a matching
// address. It then holds slave-ready until master-ready falls. Assumes the
// address and direction are stable while master-ready is high.
module pario_bus_fsm
    import pario_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] BASE_ADDR = 32'h4000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mrdy_s,
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    output logic              srdy,
    output acc_t              acc
);

    localparam int TAG_W = ADDR_W - 2;
    localparam logic [TAG_W-1:0] BASE_TAG = BASE_ADDR[ADDR_W-1:2];

    hs_state_e state;
    logic      hit;

    // Upper address bits select this port
    assign hit = (addr[ADDR_W-1:2] == BASE_TAG);

    // Access pulse: only from the idle state
    always_comb begin
        acc.en    = (state == HS_IDLE) && mrdy_s && hit;
        acc.write = write;
        acc.sel   = reg_sel_e'(addr[1:0]);
    end

    // Handshake state: acknowledge once, release when master drops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= HS_IDLE;
        end else begin
            case (state)
                HS_IDLE: if (acc.en)  state <= HS_ACK;
                HS_ACK:  if (!mrdy_s) state <= HS_IDLE;
                default: state <= HS_IDLE;
            endcase
        end
    end

    assign srdy = (state == HS_ACK);

    // R2: slave-ready only rises on a seen master-ready
    assert_srdy_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(srdy) |-> $past(mrdy_s));

    // R2: slave-ready only falls after master-ready was seen low
    assert_srdy_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(srdy) |-> !$past(mrdy_s));

endmodule

// File: rtl/pario_regs.sv
// Module: pario_regs
// Holds the input code, the output character, the two readiness flags and
// the read data register. It detects edges of the synchronized device
// strobes. On a collision, a set from a device edge beats a clear from the
// processor. Assumes dev code inputs are stable while their strobe is high.
module pario_regs
    import pario_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_t              acc,
    input  logic [CODE_W-1:0] wcode,
    input  logic [CODE_W-1:0] in_code,
    input  logic              in_valid_s,
    input  logic              idle_s,
    output logic [DATA_W-1:0] rdata,
    output logic [CODE_W-1:0] out_code,
    output logic              out_valid
);

    logic [CODE_W-1:0] in_reg;
    logic              in_flag;
    logic              out_flag;
    logic              in_valid_d;
    logic              idle_d;
    logic              in_rise;
    logic              idle_rise;
    logic              idle_fall;
    logic              rd_in;
    logic              wr_out;
    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] read_mux;

    // Previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_valid_d <= 1'b0;
            idle_d     <= 1'b0;
        end else begin
            in_valid_d <= in_valid_s;
            idle_d     <= idle_s;
        end
    end

    assign in_rise   = in_valid_s & ~in_valid_d;
    assign idle_rise = idle_s & ~idle_d;
    assign idle_fall = ~idle_s & idle_d;

    assign rd_in  = acc.en & ~acc.write & (acc.sel == SEL_IN);
    assign wr_out = acc.en &  acc.write & (acc.sel == SEL_OUT);

    // Status word: two flags at fixed positions, the rest zero
    always_comb begin
        status_word               = '0;
        status_word[STAT_IN_BIT]  = in_flag;
        status_word[STAT_OUT_BIT] = out_flag;
    end

    // Read multiplexer standing in for the bus drivers
    always_comb begin
        case (acc.sel)
            SEL_IN:   read_mux = DATA_W'(in_reg);
            SEL_OUT:  read_mux = DATA_W'(out_code);
            SEL_STAT: read_mux = status_word;
            default:  read_mux = '0;
        endcase
    end

    // Input side: capture on strobe edge, flag cleared by a data read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_reg  <= '0;
            in_flag <= 1'b0;
        end else if (in_rise) begin
            in_reg  <= in_code;
            in_flag <= 1'b1;
        end else if (rd_in) begin
            in_flag <= 1'b0;
        end
    end

    // Output flag: set by idle edge, cleared by a character write
    always_ff @(posedge clk) begin
        if (!rst_n)      out_flag <= 1'b0;
        else if (idle_rise) out_flag <= 1'b1;
        else if (wr_out) out_flag <= 1'b0;
    end

    // Output character and strobe: raised by write, dropped when idle falls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_code  <= '0;
            out_valid <= 1'b0;
        end else if (wr_out) begin
            out_code  <= wcode;
            out_valid <= 1'b1;
        end else if (idle_fall) begin
            out_valid <= 1'b0;
        end
    end

    // Read data register: loaded on each access, zero for writes
    always_ff @(posedge clk) begin
        if (!rst_n)                 rdata <= '0;
        else if (acc.en && acc.write) rdata <= '0;
        else if (acc.en)            rdata <= read_mux;
    end

    // R5: input flag rises only from a strobe edge
    assert_in_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_flag) |-> $past(in_valid_s) && !$past(in_valid_d));

    // R6: input flag falls only on a processor read of the input register
    assert_in_flag_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_flag) |-> $past(acc.en) && !$past(acc.write) && ($past(acc.sel) == SEL_IN));

    // R7: output flag rises only from an idle edge
    assert_out_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_flag) |-> $past(idle_s) && !$past(idle_d));

    // R8: output strobe rises only on a character write
    assert_out_valid_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(acc.en) && $past(acc.write) && ($past(acc.sel) == SEL_OUT));

    // R9: output strobe falls only when idle was seen falling
    assert_out_valid_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> !$past(idle_s) && $past(idle_d));

    // R10: output character changes only through a character write
    assert_out_code_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_code) |-> $past(acc.en) && $past(acc.write) && ($past(acc.sel) == SEL_OUT));

endmodule

// File: rtl/pario_port.sv
// Module: pario_port
// Top of the memory-mapped parallel port. It synchronizes the three
// asynchronous inputs, decodes and acknowledges bus accesses, and holds the
// port registers. Assumes address, direction and write data are held
// stable while master-ready is high.
module pario_port
    import pario_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter int          DATA_W      = 32,
    parameter int          CODE_W      = 8,
    parameter int          SYNC_STAGES = 2,
    parameter logic [31:0] BASE_ADDR   = 32'h4000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_write,
    input  logic              bus_mrdy,
    output logic              bus_srdy,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CODE_W-1:0] dev_in_code,
    input  logic              dev_in_valid,
    output logic [CODE_W-1:0] dev_out_code,
    output logic              dev_out_valid,
    input  logic              dev_out_idle
);

    localparam int N_ASYNC = 3;
    localparam int IDX_MRDY  = 0;
    localparam int IDX_VALID = 1;
    localparam int IDX_IDLE  = 2;

    logic [N_ASYNC-1:0] async_vec;
    logic [N_ASYNC-1:0] sync_vec;
    acc_t               acc;
    logic               unused_wdata_hi;

    assign async_vec[IDX_MRDY]  = bus_mrdy;
    assign async_vec[IDX_VALID] = dev_in_valid;
    assign async_vec[IDX_IDLE]  = dev_out_idle;

    // Only the character byte of the write data is stored
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CODE_W];

    generate
        for (genvar g = 0; g < N_ASYNC; g++) begin : g_sync
            pario_sync #(
                .STAGES (SYNC_STAGES)
            ) u_sync (
                .clk      (clk),
                .rst_n    (rst_n),
                .async_in (async_vec[g]),
                .level    (sync_vec[g])
            );
        end
    endgenerate

    pario_bus_fsm #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_bus_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .mrdy_s (sync_vec[IDX_MRDY]),
        .addr   (bus_addr),
        .write  (bus_write),
        .srdy   (bus_srdy),
        .acc    (acc)
    );

    pario_regs #(
        .DATA_W (DATA_W),
        .CODE_W (CODE_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc        (acc),
        .wcode      (bus_wdata[CODE_W-1:0]),
        .in_code    (dev_in_code),
        .in_valid_s (sync_vec[IDX_VALID]),
        .idle_s     (sync_vec[IDX_IDLE]),
        .rdata      (bus_rdata),
        .out_code   (dev_out_code),
        .out_valid  (dev_out_valid)
    );

    // R1: no acknowledge without a matching address
    assert_srdy_needs_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_srdy) |-> ($past(bus_addr[ADDR_W-1:2]) == BASE_ADDR[ADDR_W-1:2]));

endmodule

// File: tb/pario_port_bench.sv
module pario_port_bench;

    localparam int          CLK_PERIOD = 10;
    localparam int          SYNC       = 2;
    localparam int          WATCHDOG   = 20000;
    localparam logic [31:0] BASE       = 32'h4000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_write = 1'b0;
    logic        bus_mrdy = 1'b0;
    logic        bus_srdy;
    logic [31:0] bus_rdata;
    logic [7:0]  dev_in_code = '0;
    logic        dev_in_valid = 1'b0;
    logic [7:0]  dev_out_code;
    logic        dev_out_valid;
    logic        dev_out_idle = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit started = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pario_port #(
        .SYNC_STAGES (SYNC),
        .BASE_ADDR   (BASE)
    ) u_pario_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_write     (bus_write),
        .bus_mrdy      (bus_mrdy),
        .bus_srdy      (bus_srdy),
        .bus_rdata     (bus_rdata),
        .dev_in_code   (dev_in_code),
        .dev_in_valid  (dev_in_valid),
        .dev_out_code  (dev_out_code),
        .dev_out_valid (dev_out_valid),
        .dev_out_idle  (dev_out_idle)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Reference model: history of driven values, behavioural state
    bit          mh[0:7];
    bit          vh[0:7];
    bit          ih[0:7];
    bit          ref_sin, ref_sout, ref_ostb, ref_srdy;
    logic [7:0]  ref_din, ref_dout;
    logic [31:0] ref_rdata;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin mh[i] = 0; vh[i] = 0; ih[i] = 0; end
            ref_sin = 0; ref_sout = 0; ref_ostb = 0; ref_srdy = 0;
            ref_din = '0; ref_dout = '0; ref_rdata = '0;
        end else begin
            bit m_eff, v_rise, i_rise, i_fall, do_acc, rd_in, wr_out;
            for (int i = 7; i > 0; i--) begin mh[i] = mh[i-1]; vh[i] = vh[i-1]; ih[i] = ih[i-1]; end
            mh[0] = bus_mrdy; vh[0] = dev_in_valid; ih[0] = dev_out_idle;
            m_eff  = mh[SYNC];
            v_rise = vh[SYNC] && !vh[SYNC+1];
            i_rise = ih[SYNC] && !ih[SYNC+1];
            i_fall = !ih[SYNC] && ih[SYNC+1];
            do_acc = !ref_srdy && m_eff && (bus_addr[31:2] == BASE[31:2]);
            rd_in  = do_acc && !bus_write && (bus_addr[1:0] == 2'd0);
            wr_out = do_acc && bus_write && (bus_addr[1:0] == 2'd1);
            if (do_acc) begin
                if (bus_write) ref_rdata = '0;
                else case (bus_addr[1:0])
                    2'd0: ref_rdata = {24'd0, ref_din};
                    2'd1: ref_rdata = {24'd0, ref_dout};
                    2'd2: ref_rdata = {30'd0, ref_sout, ref_sin};
                    default: ref_rdata = '0;
                endcase
            end
            if (v_rise) begin ref_din = dev_in_code; ref_sin = 1; end
            else if (rd_in) ref_sin = 0;
            if (i_rise) ref_sout = 1;
            else if (wr_out) ref_sout = 0;
            if (wr_out) begin ref_dout = bus_wdata[7:0]; ref_ostb = 1; end
            else if (i_fall) ref_ostb = 0;
            if (do_acc) ref_srdy = 1;
            else if (!m_eff) ref_srdy = 0;
        end
    end

    // Compare against the model on every clock
    always @(negedge clk) begin
        if (started && rst_n) begin
            check(bus_srdy == ref_srdy, "R2 model srdy", bus_srdy, ref_srdy);
            check(bus_rdata == ref_rdata, "R3 model rdata", bus_rdata, ref_rdata);
            check(dev_out_code == ref_dout, "R8 model out_code", dev_out_code, ref_dout);
            check(dev_out_valid == ref_ostb, "R9 model out_valid", dev_out_valid, ref_ostb);
        end
    end

    task automatic bus_access(input logic [31:0] a, input logic w, input logic [31:0] wd,
                              output logic [31:0] rd);
        int n;
        @(negedge clk);
        bus_addr = a; bus_write = w; bus_wdata = wd; bus_mrdy = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!bus_srdy && n < 20);
        check(n == SYNC + 1, "R2 ack latency", n, SYNC + 1);
        rd = bus_rdata;
        bus_mrdy = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (bus_srdy && n < 20);
        check(n == SYNC + 1, "R2 release latency", n, SYNC + 1);
    endtask

    task automatic miss_access(input logic [31:0] a);
        bit seen;
        @(negedge clk);
        bus_addr = a; bus_write = 1'b0; bus_mrdy = 1'b1;
        seen = 0;
        repeat (10) begin @(negedge clk); if (bus_srdy) seen = 1; end
        check(!seen, "R1 no answer off base", seen, 0);
        bus_mrdy = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_in(input logic [7:0] code);
        @(negedge clk);
        dev_in_code = code; dev_in_valid = 1'b1;
        repeat (5) @(negedge clk);
        dev_in_valid = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        logic [31:0] rd;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        started = 1'b1;
        @(negedge clk);
        check(bus_srdy == 0, "R11 srdy after reset", bus_srdy, 0);
        check(bus_rdata == 0, "R11 rdata after reset", bus_rdata, 0);
        check(dev_out_valid == 0, "R11 out_valid after reset", dev_out_valid, 0);
        check(dev_out_code == 0, "R11 out_code after reset", dev_out_code, 0);
        bus_access(BASE | 32'd2, 1'b0, '0, rd);
        check(rd == 0, "R11 status after reset", rd, 0);

        // R1: top bit and bit 2 mismatches
        miss_access(BASE ^ 32'h8000_0000);
        miss_access(BASE + 32'd4);

        // R5/R6: input capture and clear on read
        pulse_in(8'hA5);
        bus_access(BASE | 32'd2, 1'b0, '0, rd);
        check(rd == 32'h1, "R5 input flag set", rd, 1);
        bus_access(BASE | 32'd0, 1'b0, '0, rd);
        check(rd == 32'hA5, "R5 input code captured", rd, 32'hA5);
        bus_access(BASE | 32'd2, 1'b0, '0, rd);
        check(rd == 32'h0, "R6 input flag cleared", rd, 0);
        pulse_in(8'h5A);
        bus_access(BASE | 32'd0, 1'b0, '0, rd);
        check(rd == 32'h5A, "R5 second code", rd, 32'h5A);

        // R7: idle edge sets output flag
        @(negedge clk); dev_out_idle = 1'b1;
        repeat (5) @(negedge clk);
        bus_access(BASE | 32'd2, 1'b0, '0, rd);
        check(rd == 32'h2, "R7 output flag set", rd, 2);

        // R8: character write
        bus_access(BASE | 32'd1, 1'b1, 32'hFFFF_FF3C, rd);
        check(rd == 0, "R3 write returns zero", rd, 0);
        check(dev_out_code == 8'h3C, "R8 out_code", dev_out_code, 8'h3C);
        check(dev_out_valid == 1, "R8 out_valid raised", dev_out_valid, 1);
        bus_access(BASE | 32'd2, 1'b0, '0, rd);
        check(rd == 32'h0, "R8 output flag cleared", rd, 0);
        bus_access(BASE | 32'd1, 1'b0, '0, rd);
        check(rd == 32'h3C, "R3 output register readback", rd, 32'h3C);

        // R9: strobe drops SYNC+1 edges after idle falls
        @(negedge clk); dev_out_idle = 1'b0;
        @(negedge clk);
        check(dev_out_valid == 1, "R9 strobe held edge 1", dev_out_valid, 1);
        @(negedge clk);
        check(dev_out_valid == 1, "R9 strobe held edge 2", dev_out_valid, 1);
        @(negedge clk);
        check(dev_out_valid == 0, "R9 strobe dropped", dev_out_valid, 0);

        // R10: writes elsewhere change nothing
        bus_access(BASE | 32'd0, 1'b1, 32'hFF, rd);
        bus_access(BASE | 32'd2, 1'b1, 32'h3, rd);
        bus_access(BASE | 32'd3, 1'b1, 32'hFF, rd);
        bus_access(BASE | 32'd0, 1'b0, '0, rd);
        check(rd == 32'h5A, "R10 input register kept", rd, 32'h5A);
        bus_access(BASE | 32'd2, 1'b0, '0, rd);
        check(rd == 32'h0, "R10 status kept", rd, 0);
        check(dev_out_code == 8'h3C, "R10 out_code kept", dev_out_code, 8'h3C);
        check(dev_out_valid == 0, "R10 out_valid kept", dev_out_valid, 0);

        // R3: unmapped read
        bus_access(BASE | 32'd3, 1'b0, '0, rd);
        check(rd == 32'h0, "R3 unmapped reads zero", rd, 0);

        // R4: both flags together
        @(negedge clk); dev_out_idle = 1'b1;
        pulse_in(8'h11);
        bus_access(BASE | 32'd2, 1'b0, '0, rd);
        check(rd == 32'h3, "R4 both flags", rd, 3);

        // R8: second character
        bus_access(BASE | 32'd1, 1'b1, 32'h0000_0081, rd);
        check(dev_out_code == 8'h81, "R8 second character", dev_out_code, 8'h81);
        bus_access(BASE | 32'd2, 1'b0, '0, rd);
        check(rd == 32'h1, "R8 only output flag cleared", rd, 1);

        repeat (5) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired (R2 handshake stalled) actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule